// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block sits inside one UART channel and turns a set of eight interrupt requests into a single read-only identification byte and an active-low interrupt pin. Each request arrives as a level with its own enable bit. The block finds the highest-ranked request that is both raised and enabled, and places that request's fixed 5-bit code in bits 5:1 of the byte. Bit 0 is a pending flag that is low when something is pending. Both bits 7:6 copy the FIFO-enable control bit.

The byte is registered once per clock, so a host read always sees a stable snapshot. The transmit-holding-empty source is the only one that is latched. A rising edge of its request sets the latch, and a host read of the byte while the transmit-empty code is shown clears it. All other sources follow their request levels directly. For the modem and pin-change sources the code only names the cause; their detailed status is kept outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `identByte` is 0x01 and `irqN` is 1.
- R2: `identByte[0]` is 0 exactly when some enabled source is pending, and `irqN` always equals `identByte[0]`.
- R3: `identByte[7]` and `identByte[6]` both equal the value `fifoEn` had at the previous clock edge.
- R4: Request index to code in `identByte[5:0]`: 0 line-status error 0x06, 1 receiver time-out 0x0C, 2 receive data available 0x04, 3 transmit-holding empty 0x02, 4 modem status 0x00, 5 input pin change 0x30, 6 Xoff/special character 0x10, 7 CTS/RTS going inactive 0x20. With nothing pending, bits 5:1 are zero.
- R5: When several enabled sources are pending, only the lowest index is reported (index 0 is ranked highest, index 7 lowest).
- R6: When receiver time-out (index 1) and receive data (index 2) are both pending at the shared level, the time-out code 0x0C is reported.
- R7: A raised request whose `srcEn` bit is 0 is ignored: it is not reported and does not hide a lower-ranked enabled source.
- R8: The transmit-empty source (index 3) is latched on a rising edge of `srcReq[3]` and stays pending after `srcReq[3]` falls.
- R9: A `readStrobe` cycle while `identByte[5:0]` shows 0x02 clears the transmit-empty latch. A read while any other code is shown leaves the latch set.
- R10: Sources other than index 3 follow their request levels. A read does not clear them.
- R11: The byte reflects the inputs present at the previous clock edge. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 8 | Request level for each source, indexed as in R4 |
| srcEn | input | 8 | Enable bit for each source |
| fifoEn | input | 1 | FIFO-enable control bit, copied into bits 7:6 |
| readStrobe | input | 1 | High for one cycle when the host reads the byte |
| identByte | output | 8 | Identification byte |
| irqN | output | 1 | Interrupt pin, low while a source is pending |

## Verification
Every result is due one clock edge after the stimulus that causes it. This includes the copied FIFO bit, the newly ranked code, a latched transmit-empty event, and the clearing that a read causes. The bench drives its inputs a quarter period after an edge. It then waits for the next rising edge and samples a quarter period later, so each check sees exactly one register update. One check samples just before an edge and confirms that the old value still holds, which covers R11.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 8;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int CODE_W  = 5;
  localparam int BYTE_W  = 8;
  localparam int TX_IDX  = 3;

  typedef struct packed {
    logic txSet;
    logic txClr;
  } ctrlStrobes_t;

  // Codes for bits 5:1, one per source index
  function automatic logic [CODE_W-1:0] srcCode(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    srcCode = 5'h03;
      3'd1:    srcCode = 5'h06;
      3'd2:    srcCode = 5'h02;
      3'd3:    srcCode = 5'h01;
      3'd4:    srcCode = 5'h00;
      3'd5:    srcCode = 5'h18;
      3'd6:    srcCode = 5'h08;
      default: srcCode = 5'h10;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txReq,
  input  logic              readStrobe,
  input  logic [CODE_W-1:0] shownCode,
  input  logic              shownPending,
  output ctrlStrobes_t      strobes
);
  logic txPrev;

  always_ff @(posedge clk) begin
    if (!rstN) txPrev <= 1'b0;
    else       txPrev <= txReq;
  end

  always_comb begin
    strobes.txSet = txReq & ~txPrev;
    strobes.txClr = readStrobe & shownPending & (shownCode == srcCode(IDX_W'(TX_IDX)));
  end
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               fifoEn,
  input  ctrlStrobes_t       strobes,
  output logic [BYTE_W-1:0]  identReg
);
  logic               txLatch;
  logic               txLive;
  logic [NUM_SRC-1:0] liveReq;
  logic [NUM_SRC-1:0] effReq;
  logic [IDX_W-1:0]   winIdx;
  logic               anyHit;
  logic [CODE_W-1:0]  winCode;

  // a new edge wins over a clear in the same cycle
  assign txLive = strobes.txSet | (txLatch & ~strobes.txClr);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_live
    if (g == TX_IDX) begin : g_tx
      assign liveReq[g] = txLive;
    end else begin : g_lvl
      assign liveReq[g] = srcReq[g];
    end
  end

  assign effReq = liveReq & srcEn;

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (effReq[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
    winCode = anyHit ? srcCode(winIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLatch  <= 1'b0;
      identReg <= 8'h01;
    end else begin
      txLatch  <= txLive;
      identReg <= {fifoEn, fifoEn, winCode, ~anyHit};
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               fifoEn,
  input  logic               readStrobe,
  output logic [BYTE_W-1:0]  identByte,
  output logic               irqN
);
  ctrlStrobes_t       strobes;
  logic [BYTE_W-1:0]  identReg;

  uart_irq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txReq        (srcReq[TX_IDX]),
    .readStrobe   (readStrobe),
    .shownCode    (identReg[CODE_W:1]),
    .shownPending (~identReg[0]),
    .strobes      (strobes)
  );

  uart_irq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcReq   (srcReq),
    .srcEn    (srcEn),
    .fifoEn   (fifoEn),
    .strobes  (strobes),
    .identReg (identReg)
  );

  assign identByte = identReg;
  assign irqN      = identReg[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] srcReq,
  input logic [7:0] srcEn,
  input logic       fifoEn,
  input logic       readStrobe,
  input logic [7:0] identByte,
  input logic       irqN
);
  a_r3_fifo_mirror: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> identByte[7:6] == {2{$past(fifoEn)}});

  a_r7_none_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn == 8'h00) |=> identByte[5:0] == 6'h01);

  a_r5_line_status_top: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq[0] && srcEn[0]) |=> identByte[5:0] == 6'h06);

  a_r9_tx_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && identByte[5:0] == 6'h02 && !srcReq[3]) |=> identByte[5:0] != 6'h02);

  a_r2_level_pends: assert property (@(posedge clk) disable iff (!rstN)
    ((srcReq & srcEn & 8'hF7) != 8'h00) |=> (!irqN && !identByte[0]));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcReq     (srcReq),
  .srcEn      (srcEn),
  .fifoEn     (fifoEn),
  .readStrobe (readStrobe),
  .identByte  (identByte),
  .irqN       (irqN)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcReq = '0;
  logic [7:0] srcEn = '0;
  logic       fifoEn = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] identByte;
  logic       irqN;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn),
    .fifoEn(fifoEn), .readStrobe(readStrobe), .identByte(identByte), .irqN(irqN)
  );

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    srcReq = '0; srcEn = '0; fifoEn = 1'b0; readStrobe = 1'b0;
    step(); step();
  endtask

  task automatic testReset();
    check("R1 ident", identByte, 8'h01);
    check("R1 irqN", {7'd0, irqN}, 8'h01);
  endtask

  task automatic testCodes();
    logic [7:0] codes [8];
    codes = '{8'h06, 8'h0C, 8'h04, 8'h02, 8'h00, 8'h30, 8'h10, 8'h20};
    for (int i = 0; i < 8; i++) begin
      srcEn = 8'hFF; srcReq = 8'h01 << i;
      step();
      check("R4 code", identByte, codes[i]);
      check("R2 irqN low", {7'd0, irqN}, 8'h00);
      srcReq = '0;
      if (i == 3) begin readStrobe = 1'b1; step(); readStrobe = 1'b0; end
      step();
      check("R2 idle", identByte, 8'h01);
    end
  endtask

  task automatic testPriority();
    logic [7:0] order [7];
    logic [7:0] expv [7];
    order = '{8'd0, 8'd1, 8'd2, 8'd4, 8'd5, 8'd6, 8'd7};
    expv  = '{8'h0C, 8'h04, 8'h00, 8'h30, 8'h10, 8'h20, 8'h01};
    srcEn = 8'hFF; srcReq = 8'hF7;
    step();
    check("R5 all pending", identByte, 8'h06);
    for (int i = 0; i < 7; i++) begin
      srcReq[order[i]] = 1'b0;
      step();
      check(i == 0 ? "R6 timeout over rxdata" : "R5 next rank", identByte, expv[i]);
    end
  endtask

  task automatic testDisabled();
    srcReq = 8'h21; srcEn = 8'h20;
    step();
    check("R7 disabled ignored", identByte, 8'h30);
    srcReq = 8'h02; srcEn = 8'h00;
    step();
    check("R7 none enabled", identByte, 8'h01);
    clearAll();
  endtask

  task automatic testFifo();
    fifoEn = 1'b1;
    step();
    check("R3 mirror idle", identByte, 8'hC1);
    srcEn = 8'hFF; srcReq = 8'h01;
    step();
    check("R3 mirror pending", identByte, 8'hC6);
    clearAll();
    check("R3 mirror off", identByte, 8'h01);
  endtask

  task automatic testTxLatch();
    srcEn = 8'hFF; srcReq = 8'h18;
    step();
    check("R8 tx set", identByte, 8'h02);
    srcReq = 8'h10;
    step();
    check("R8 tx held", identByte, 8'h02);
    readStrobe = 1'b1;
    step();
    readStrobe = 1'b0;
    check("R9 tx cleared", identByte, 8'h00);
    readStrobe = 1'b1;
    step();
    readStrobe = 1'b0;
    check("R10 modem stays", identByte, 8'h00);
    srcReq = 8'h09;
    step();
    srcReq = 8'h01;
    check("R5 line over tx", identByte, 8'h06);
    readStrobe = 1'b1;
    step();
    readStrobe = 1'b0;
    srcReq = 8'h00;
    step();
    check("R9 read elsewhere keeps tx", identByte, 8'h02);
    readStrobe = 1'b1;
    step();
    readStrobe = 1'b0;
    check("R9 final clear", identByte, 8'h01);
  endtask

  task automatic testLatency();
    srcEn = 8'hFF; srcReq = 8'h20;
    #(CLK_PERIOD/4);
    check("R11 before edge", identByte, 8'h01);
    step();
    check("R11 after edge", identByte, 8'h30);
    clearAll();
  endtask

  initial begin
    step(); step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testCodes();
    testPriority();
    clearAll();
    testDisabled();
    testFifo();
    testTxLatch();
    clearAll();
    testLatency();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule